// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt sources and drives two request lines toward a processor. The fast request line serves one dedicated external pin. The normal request line serves one external interrupt pin (source 0) together with `NUM_INT` on-chip peripheral lines (sources 1 to `NUM_INT`). Each normal source has an enable bit, a 3-bit priority, a choice between level and edge triggering and, on the external pin only, a choice of polarity. The two external pins are synchronized before they are used.

Software works through a small word-addressed register port. A read of the current-source register returns the winning source and also acknowledges it: the source's edge latch clears and its priority is pushed on an 8-entry service stack. While the stack is not empty, the normal request is raised only by sources whose priority is strictly above the stack top. A write to the end-of-service register pops the stack. This gives nested, preemptive servicing with no software bookkeeping.

Register map (5-bit word address): 0 enable mask, 1 current source (read), 2 end of service (write), 3 fast-pin mode, 4 fast-latch clear (write), 5 pending mask (read), 8+s mode of source s. With the defaults, at most 8 normal sources are supported (`NUM_INT` up to 7).

Top module: `prio_irq_ctrl`

## Requirements
- R1: `fiq_o` depends only on `fiq_pin_i` and on the fast-mode register at address 3 (bit 3 = edge, bit 4 = active-low/falling). In level mode it follows the synchronized pin. In edge mode a detected edge latches it high until any write to address 4 clears it.
- R2: `irq_o` can be raised only by a source that is both pending and enabled. Enable bit s of address 0 gates source s. Source 0 is `irq_pin_i` and source s>0 is `periph_irq_i[s-1]`.
- R3: The mode register of source s sits at address 8+s: bits 2:0 = priority, bit 3 = edge mode, bit 4 = active-low/falling. Bit 4 has no effect on peripheral sources, which always trigger on a high level or a rising edge.
- R4: Each external pin passes through a two-flop synchronizer. Source 0 can be set to a high level, a low level, a rising edge or a falling edge. An edge is held in a latch that stays set after the pin returns.
- R5: The winner is the pending, enabled source with the highest priority. When priorities are equal, the lowest source number wins.
- R6: A read of address 1 returns bit 31 = request valid, bits 10:8 = priority and bits 7:0 = source number of the winner, or zero when `irq_o` is low. A valid read acknowledges the winner: its edge latch clears and its priority is pushed on the stack.
- R7: While the stack holds entries, `irq_o` is raised only by sources whose priority is strictly higher than the stack top. A write to address 2 pops one entry, and such a write to an empty stack has no effect.
- R8: If a new edge arrives on a source in the same cycle as that source's acknowledge, the new edge wins and the source stays pending.
- R9: A read of address 5 returns the pending bit of every source, with or without enable.
- R10: The stack never holds more than 8 entries, and each push is above the previous top.
- R11: After reset, both outputs are low, all sources are disabled, all modes are zero (level, high, priority 0) and the stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| fiq_pin_i | input | 1 | external fast-interrupt pin (asynchronous) |
| irq_pin_i | input | 1 | external normal-interrupt pin, source 0 (asynchronous) |
| periph_irq_i | input | NUM_INT | on-chip peripheral requests, sources 1..NUM_INT |
| bus_wr_i | input | 1 | register write strobe |
| bus_rd_i | input | 1 | register read strobe |
| bus_addr_i | input | 5 | register word address |
| bus_wdata_i | input | 32 | write data |
| bus_rdata_o | output | 32 | read data, valid the cycle after the read strobe |
| fiq_o | output | 1 | fast interrupt request |
| irq_o | output | 1 | normal interrupt request |

## Verification
The sharpest collision is an acknowledge that clears a source's edge latch in the same cycle that a fresh edge on the same pin tries to set it. The bench counts the synchronizer stages so that the read strobe lands on exactly the edge where the edge-detect term is live. After the service is closed it expects the source to still be pending. A second overlap, a push and a masked request, is judged across a swept priority table: after each acknowledge the request must drop, and after each end-of-service it must return.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int PRIO_W = 3;

    localparam logic [4:0] ADR_ENABLE = 5'd0;
    localparam logic [4:0] ADR_CUR    = 5'd1;
    localparam logic [4:0] ADR_EOI    = 5'd2;
    localparam logic [4:0] ADR_FCFG   = 5'd3;
    localparam logic [4:0] ADR_FCLR   = 5'd4;
    localparam logic [4:0] ADR_PEND   = 5'd5;
    localparam logic [1:0] ADR_CFG_HI = 2'b01;

    typedef struct packed {
        logic              pol_n;
        logic              edge_m;
        logic [PRIO_W-1:0] prio;
    } src_cfg_t;

endpackage

// File: rtl/vic_sync.sv
module vic_sync #(
    parameter int W = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = pin_i;
        sync_d.s2 = sync_q.s1;
        sync_d.s3 = sync_q.s2;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= sync_d;
    end

    assign lvl_o  = sync_q.s2;
    assign rise_o = sync_q.s2 & ~sync_q.s3;
    assign fall_o = ~sync_q.s2 & sync_q.s3;

endmodule

// File: rtl/vic_penc.sv
module vic_penc #(
    parameter int N  = 7,
    parameter int PW = 3,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]         req_i,
    input  logic [N-1:0][PW-1:0] prio_i,
    output logic                 valid_o,
    output logic [IW-1:0]        idx_o,
    output logic [PW-1:0]        prio_o
);

    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        prio_o  = '0;
        for (int s = 0; s < N; s++) begin
            if (req_i[s] && (!valid_o || prio_i[s] > prio_o)) begin
                valid_o = 1'b1;
                idx_o   = IW'(s);
                prio_o  = prio_i[s];
            end
        end
    end

endmodule

// File: rtl/vic_stack.sv
module vic_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 3,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [W-1:0]  din_i,
    output logic [W-1:0]  top_o,
    output logic [CW-1:0] cnt_o,
    output logic          empty_o
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] ent;
        logic [CW-1:0]           cnt;
    } stk_t;

    stk_t stk_d, stk_q;

    always_comb begin
        stk_d = stk_q;
        if (push_i) begin
            if (stk_q.cnt < CW'(DEPTH)) begin
                stk_d.ent[PW'(stk_q.cnt)] = din_i;
                stk_d.cnt                 = stk_q.cnt + CW'(1);
            end
        end else if (pop_i) begin
            if (stk_q.cnt != '0) stk_d.cnt = stk_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stk_q <= '0;
        else         stk_q <= stk_d;
    end

    assign empty_o = (stk_q.cnt == '0);
    assign cnt_o   = stk_q.cnt;
    assign top_o   = empty_o ? '0 : stk_q.ent[PW'(stk_q.cnt - CW'(1))];

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import vic_pkg::*;
#(
    parameter int NUM_INT   = 6,
    parameter int STK_DEPTH = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               fiq_pin_i,
    input  logic               irq_pin_i,
    input  logic [NUM_INT-1:0] periph_irq_i,
    input  logic               bus_wr_i,
    input  logic               bus_rd_i,
    input  logic [4:0]         bus_addr_i,
    input  logic [31:0]        bus_wdata_i,
    output logic [31:0]        bus_rdata_o,
    output logic               fiq_o,
    output logic               irq_o
);

    localparam int N  = NUM_INT + 1;
    localparam int IW = (N > 1) ? $clog2(N) : 1;
    localparam int CW = $clog2(STK_DEPTH + 1);

    typedef struct packed {
        logic [N-1:0]       en;
        src_cfg_t [N-1:0]   cfg;
        src_cfg_t           fcfg;
        logic [N-1:0]       lat;
        logic               flat;
        logic [NUM_INT-1:0] prev;
        logic [31:0]        rdata;
    } ctl_t;

    ctl_t q, d;

    // external pins: bit 0 fast, bit 1 normal source 0
    logic [1:0] sync_lvl, sync_rise, sync_fall;

    vic_sync #(.W(2)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  ({irq_pin_i, fiq_pin_i}),
        .lvl_o  (sync_lvl),
        .rise_o (sync_rise),
        .fall_o (sync_fall)
    );

    logic fast_lvl;
    assign fast_lvl = sync_lvl[0];

    // per-source activity
    logic [N-1:0]                 lvl_act, edge_hit, pending;
    logic [N-1:0][PRIO_W-1:0]     prio_vec;

    always_comb begin
        lvl_act[0]  = sync_lvl[1] ^ q.cfg[0].pol_n;
        edge_hit[0] = q.cfg[0].pol_n ? sync_fall[1] : sync_rise[1];
        for (int i = 0; i < NUM_INT; i++) begin
            lvl_act[i+1]  = periph_irq_i[i];
            edge_hit[i+1] = periph_irq_i[i] & ~q.prev[i];
        end
        for (int s = 0; s < N; s++) begin
            pending[s]  = q.cfg[s].edge_m ? q.lat[s] : lvl_act[s];
            prio_vec[s] = q.cfg[s].prio;
        end
    end

    logic              sel_valid;
    logic [IW-1:0]     sel_idx;
    logic [PRIO_W-1:0] sel_prio;

    vic_penc #(.N(N), .PW(PRIO_W)) u_penc (
        .req_i   (pending & q.en),
        .prio_i  (prio_vec),
        .valid_o (sel_valid),
        .idx_o   (sel_idx),
        .prio_o  (sel_prio)
    );

    logic              stk_empty;
    logic [PRIO_W-1:0] stk_top;
    logic [CW-1:0]     stk_cnt;
    logic              eligible, ack, eoi;

    assign eligible = sel_valid && (stk_empty || sel_prio > stk_top);
    assign ack      = bus_rd_i && (bus_addr_i == ADR_CUR) && eligible;
    assign eoi      = bus_wr_i && (bus_addr_i == ADR_EOI);

    vic_stack #(.DEPTH(STK_DEPTH), .W(PRIO_W)) u_stack (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .push_i  (ack),
        .pop_i   (eoi),
        .din_i   (sel_prio),
        .top_o   (stk_top),
        .cnt_o   (stk_cnt),
        .empty_o (stk_empty)
    );

    // fast path
    logic fast_hit, fast_act;
    assign fast_act = fast_lvl ^ q.fcfg.pol_n;
    assign fast_hit = q.fcfg.pol_n ? sync_fall[0] : sync_rise[0];

    logic       cfg_hit;
    logic [2:0] cfg_idx;
    assign cfg_hit = (bus_addr_i[4:3] == ADR_CFG_HI);
    assign cfg_idx = bus_addr_i[2:0];

    always_comb begin
        d      = q;
        d.prev = periph_irq_i;
        for (int s = 0; s < N; s++) begin
            d.lat[s] = (edge_hit[s] && q.cfg[s].edge_m)
                     || (q.lat[s] && !(ack && sel_idx == IW'(s)));
        end
        d.flat = (fast_hit && q.fcfg.edge_m)
               || (q.flat && !(bus_wr_i && bus_addr_i == ADR_FCLR));
        if (bus_wr_i) begin
            if (bus_addr_i == ADR_ENABLE) d.en   = bus_wdata_i[N-1:0];
            if (bus_addr_i == ADR_FCFG)   d.fcfg = src_cfg_t'(bus_wdata_i[4:0]);
            for (int s = 0; s < N; s++) begin
                if (cfg_hit && int'(cfg_idx) == s) d.cfg[s] = src_cfg_t'(bus_wdata_i[4:0]);
            end
        end
        if (bus_rd_i) begin
            d.rdata = '0;
            if (bus_addr_i == ADR_ENABLE) d.rdata[N-1:0] = q.en;
            if (bus_addr_i == ADR_CUR && eligible)
                d.rdata = {1'b1, 20'd0, sel_prio, 8'(sel_idx)};
            if (bus_addr_i == ADR_FCFG) d.rdata[4:0] = q.fcfg;
            if (bus_addr_i == ADR_PEND) d.rdata[N-1:0] = pending;
            for (int s = 0; s < N; s++) begin
                if (cfg_hit && int'(cfg_idx) == s) d.rdata[4:0] = q.cfg[s];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    logic [N-1:0] en_vec;
    assign en_vec      = q.en;
    assign bus_rdata_o = q.rdata;
    assign irq_o       = eligible;
    assign fiq_o       = q.fcfg.edge_m ? q.flat : fast_act;

    logic unused_wdata;
    assign unused_wdata = ^bus_wdata_i[31:N];

endmodule

// File: rtl/vic_chk.sv
module vic_chk #(
    parameter int N     = 7,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          bus_rd_i,
    input logic          bus_wr_i,
    input logic [4:0]    bus_addr_i,
    input logic [31:0]   bus_rdata_o,
    input logic          irq_o,
    input logic          fiq_o,
    input logic          fast_lvl,
    input logic [CW-1:0] stk_cnt,
    input logic [2:0]    stk_top,
    input logic          stk_empty,
    input logic [N-1:0]  en_q
);

    // R10: bounded depth
    a_r10_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stk_cnt <= CW'(DEPTH));

    // R10: each push lands above the previous top
    a_r10_push_rises: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_rd_i && bus_addr_i == 5'd1 && irq_o && !stk_empty) |=> stk_top > $past(stk_top));

    // R6: a valid acknowledge grows the stack by one
    a_r6_ack_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_rd_i && bus_addr_i == 5'd1 && irq_o) |=> stk_cnt == $past(stk_cnt) + CW'(1));

    // R6: valid flag of the returned word mirrors the request at read time
    a_r6_valid_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_rd_i && bus_addr_i == 5'd1) |=> bus_rdata_o[31] == $past(irq_o));

    // R7: end of service pops one entry
    a_r7_eoi_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && bus_addr_i == 5'd2 && !stk_empty) |=> stk_cnt == $past(stk_cnt) - CW'(1));

    // R7: end of service on an empty stack leaves it empty
    a_r7_eoi_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && bus_addr_i == 5'd2 && stk_empty) |=> stk_empty);

    // R2: no request without an enabled source
    a_r2_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> en_q != '0);

    // R1: fast request rises only after fast-pin activity or a register write
    a_r1_fast_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(fiq_o) |-> ($past(bus_wr_i) || fast_lvl != $past(fast_lvl)
                          || $past(fast_lvl) != $past(fast_lvl, 2)));

endmodule

bind prio_irq_ctrl vic_chk #(.N(N), .DEPTH(STK_DEPTH)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_rd_i    (bus_rd_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_o       (irq_o),
    .fiq_o       (fiq_o),
    .fast_lvl    (fast_lvl),
    .stk_cnt     (stk_cnt),
    .stk_top     (stk_top),
    .stk_empty   (stk_empty),
    .en_q        (en_vec)
);

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fpin = 1'b0, ipin = 1'b0;
    logic [5:0]  per = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        fiq, irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    prio_irq_ctrl u0 (
        .clk_i(clk), .rst_ni(rst_n), .fiq_pin_i(fpin), .irq_pin_i(ipin),
        .periph_irq_i(per), .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .fiq_o(fiq), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [31:0] v);
        @(negedge clk); wr = 1'b1; addr = a; wdata = v;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [4:0] a, output logic [31:0] v);
        @(negedge clk); rd = 1'b1; addr = a;
        @(negedge clk); rd = 1'b0; v = rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int prio_of(input int k, input int i);
        return (k < 8) ? ((3 * i + k) % 8) : ((i / 2 + k) % 8);
    endfunction

    function automatic logic [31:0] exp_cur(input int k, input logic [5:0] m);
        int best = -1;
        int bp = -1;
        for (int i = 1; i <= 6; i++)
            if (m[i-1] && prio_of(k, i) > bp) begin best = i; bp = prio_of(k, i); end
        if (best < 0) return 32'd0;
        return 32'h8000_0000 | 32'(bp << 8) | 32'(best);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        settle(3);
        rst_n = 1'b1;
        settle(2);

        // R11: reset state
        chk("R11 irq", 32'(irq), 0);
        chk("R11 fiq", 32'(fiq), 0);
        rd_reg(5'd0, v); chk("R11 enable", v, 0);
        rd_reg(5'd8, v); chk("R11 mode0", v, 0);
        rd_reg(5'd5, v); chk("R11 pending", v, 0);

        // R5 R6 R2 R7: sweep of priority tables and request masks
        wr_reg(5'd0, 32'h7E);
        for (int k = 0; k < 16; k++) begin
            for (int i = 1; i <= 6; i++) wr_reg(5'(8 + i), 32'(prio_of(k, i)));
            for (int m = 0; m < 64; m++) begin
                per = 6'(m);
                settle(1);
                chk("R2 request", 32'(irq), 32'(m != 0));
                rd_reg(5'd1, v);
                chk("R5 R6 winner", v, exp_cur(k, 6'(m)));
                chk("R7 masked after ack", 32'(irq), 0);
                wr_reg(5'd2, 0);
                chk("R7 resumes after pop", 32'(irq), 32'(m != 0));
                per = '0;
            end
        end
        settle(2);

        // R4 R3: external source modes
        wr_reg(5'd0, 32'h01);
        wr_reg(5'd8, 32'h04);
        ipin = 1'b1; settle(4); chk("R4 high level on", 32'(irq), 1);
        ipin = 1'b0; settle(4); chk("R4 high level off", 32'(irq), 0);
        wr_reg(5'd8, 32'h14);
        settle(1); chk("R4 low level on", 32'(irq), 1);
        ipin = 1'b1; settle(4); chk("R4 low level off", 32'(irq), 0);
        ipin = 1'b0; settle(4);
        wr_reg(5'd8, 32'h0C);
        chk("R4 rising idle", 32'(irq), 0);
        ipin = 1'b1; settle(4); ipin = 1'b0; settle(4);
        chk("R4 rising latched", 32'(irq), 1);
        rd_reg(5'd1, v); chk("R6 ext cur", v, 32'h8000_0400);
        rd_reg(5'd5, v); chk("R6 edge latch cleared", v & 32'h1, 0);
        wr_reg(5'd2, 0);
        wr_reg(5'd8, 32'h1C);
        ipin = 1'b1; settle(4); chk("R4 falling ignores rise", 32'(irq), 0);
        ipin = 1'b0; settle(4); chk("R4 falling latched", 32'(irq), 1);
        rd_reg(5'd1, v); wr_reg(5'd2, 0);
        chk("R4 falling cleared", 32'(irq), 0);

        // R8: new edge in the acknowledge cycle
        wr_reg(5'd8, 32'h0C);
        ipin = 1'b1; settle(4); ipin = 1'b0; settle(4);
        chk("R8 armed", 32'(irq), 1);
        @(negedge clk); ipin = 1'b1;
        @(negedge clk);
        @(negedge clk); rd = 1'b1; addr = 5'd1;
        @(negedge clk); rd = 1'b0; v = rdata;
        chk("R8 ack value", v, 32'h8000_0400);
        rd_reg(5'd5, v); chk("R8 still pending", v & 32'h1, 1);
        wr_reg(5'd2, 0);
        chk("R8 request back", 32'(irq), 1);
        rd_reg(5'd1, v); wr_reg(5'd2, 0);
        ipin = 1'b0; settle(4);
        chk("R8 drained", 32'(irq), 0);

        // R1: fast path
        fpin = 1'b1; settle(4); chk("R1 fast high", 32'(fiq), 1);
        fpin = 1'b0; settle(4); chk("R1 fast low", 32'(fiq), 0);
        wr_reg(5'd0, 32'h7F); wr_reg(5'd8, 32'h04);
        ipin = 1'b1; per = 6'h3F; settle(4);
        chk("R1 normal sources leave fast line", 32'(fiq), 0);
        chk("R2 normal line up", 32'(irq), 1);
        ipin = 1'b0; per = '0; wr_reg(5'd0, 0); settle(4);
        wr_reg(5'd3, 32'h10); chk("R1 fast active low", 32'(fiq), 1);
        wr_reg(5'd3, 32'h08);
        fpin = 1'b1; settle(4); fpin = 1'b0; settle(4);
        chk("R1 fast edge latched", 32'(fiq), 1);
        wr_reg(5'd4, 0); chk("R1 fast cleared", 32'(fiq), 0);

        // R3: polarity bit ignored on peripheral source, edge mode on peripheral
        wr_reg(5'd0, 32'h02);
        wr_reg(5'd9, 32'h11);
        per = 6'h01; settle(1);
        rd_reg(5'd5, v); chk("R3 polarity ignored pending", v & 32'h2, 32'h2);
        chk("R3 polarity ignored request", 32'(irq), 1);
        per = '0; settle(1);
        rd_reg(5'd5, v); chk("R3 level released", v & 32'h2, 0);
        wr_reg(5'd0, 32'h04);
        wr_reg(5'd10, 32'h0A);
        @(negedge clk); per = 6'h02; @(negedge clk); per = '0; settle(1);
        rd_reg(5'd5, v); chk("R3 peripheral edge latched", v & 32'h4, 32'h4);
        rd_reg(5'd1, v); chk("R6 peripheral cur", v, 32'h8000_0202);
        rd_reg(5'd5, v); chk("R6 peripheral latch cleared", v & 32'h4, 0);
        wr_reg(5'd2, 0);

        // R9 R2: pending visible while disabled
        wr_reg(5'd0, 0);
        wr_reg(5'd11, 32'h05);
        per = 6'h04; settle(1);
        rd_reg(5'd5, v); chk("R9 pending while disabled", v & 32'h8, 32'h8);
        chk("R2 disabled gives no request", 32'(irq), 0);
        per = '0;

        // R7: nesting with strict priority
        wr_reg(5'd0, 32'h0E);
        wr_reg(5'd9, 32'h02); wr_reg(5'd10, 32'h05); wr_reg(5'd11, 32'h05);
        wr_reg(5'd2, 0);
        per = 6'h01; settle(1);
        chk("R7 empty pop ignored", 32'(irq), 1);
        rd_reg(5'd1, v); chk("R7 first level", v, 32'h8000_0201);
        chk("R7 same source masked", 32'(irq), 0);
        per = 6'h03; settle(1);
        chk("R7 preempt", 32'(irq), 1);
        rd_reg(5'd1, v); chk("R7 second level", v, 32'h8000_0502);
        per = 6'h07; settle(1);
        chk("R7 equal priority masked", 32'(irq), 0);
        rd_reg(5'd1, v); chk("R6 masked read zero", v, 0);
        wr_reg(5'd2, 0);
        chk("R7 after pop", 32'(irq), 1);
        rd_reg(5'd1, v); chk("R5 tie lowest number", v, 32'h8000_0502);
        wr_reg(5'd2, 0); wr_reg(5'd2, 0);
        per = '0; settle(1);
        chk("R7 all closed", 32'(irq), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule